// File: doc/BRIEF.md
# Coprocessor Deferred Exception Responder

This block is the control side of a coprocessor that a host CPU drives through four word-wide registers: a general-instruction start register, a conditional-instruction start register, a response register and an instruction address register. The host writes a start word and then reads the response register to learn what to do next.

For a general instruction the block asks for the instruction's address and frees the host at once. When that address arrives it hands the operation and the address to an external execution engine, then runs alongside the host. A fault from the engine is not reported when it occurs. It is parked, together with the faulting instruction's address. When the host next starts a general or conditional instruction, the block answers with a pre-instruction exception carrying the parked vector and does not begin that instruction. The host can then handle the fault and restart the instruction from scratch. Start words that carry the wrong tag also get a pre-instruction exception, with a fixed vector.

Conditional starts are answered at once with the selected condition flag. The fault address stays readable until software wipes it.

Top module: `cpx_defer_resp`

## Requirements
- R1: After reset, exec_start is low, bus_rdata is zero, and the first read of the response register (index 2) returns the null code 0x0000.
- R2: When the block is idle and has no fault parked, a start word whose bits [15:12] are not 0xC (written to index 0) or not 0xD (written to index 1) yields the response 0xE000 OR UNREC_VEC (default 0x0B) in bits [7:0]. No exec_start pulse follows.
- R3: When the block is idle and has no fault parked, a general start word (bits [15:12] = 0xC at index 0) yields the release response 0x4800: code 010 in bits [15:13], the come-again bit 12 = 0, and the address-request bit 11 = 1. No exec_start pulse occurs until the address is written.
- R4: A write to index 3 that follows a release gives a one-cycle exec_start pulse in the cycle after the write. During that pulse exec_op equals bits [11:0] of the start word and exec_addr equals the written value. A write to index 3 at any other time produces no pulse.
- R5: A start write at index 0 or 1, made while an address is awaited or the engine is running and no fault is parked, yields the busy code 0x2000. This outranks the check for an unrecognised tag.
- R6: An exec_done pulse with exec_fault high during a run is not reported at once. The response register keeps its contents, and index 3 reads back the address of the running instruction.
- R7: While a fault is parked, the next start write at index 0 or 1 yields 0xE000 OR the parked vector. No instruction begins: there is no release, and a later write to index 3 gives no pulse.
- R8: Reading that deferred exception response clears the parked fault, so the next start is handled as in R2, R3, R5 and R11.
- R9: The fault address at index 3 is not changed by later start writes or address writes. A write of any value to index 2 clears it to zero.
- R10: Each response read consumes the response. Reads return 0x0000 until the next start write.
- R11: When the block is idle and has no fault parked, a conditional start word (bits [15:12] = 0xD at index 1) yields 0x6000, with bit 0 set to cond_flags[bits [2:0]].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register index: 0 general start, 1 conditional start, 2 response, 3 instruction address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| exec_start | output | 1 | One-cycle launch pulse to the execution engine |
| exec_op | output | 12 | Operation field of the launched instruction |
| exec_addr | output | 32 | Host-supplied address of the launched instruction |
| exec_done | input | 1 | Engine completion pulse |
| exec_fault | input | 1 | Qualifies exec_done as a faulting completion |
| exec_vec | input | 8 | Exception vector supplied with a fault |
| cond_flags | input | 8 | Condition flags selected by conditional starts |

## Verification
Directed sequences walk the full deferred cycle: release, address, faulting completion, the next start refused with the parked vector, acknowledgement, and restart. These sequences show that a fault is held back rather than reported early, and that the refused instruction never reaches the engine. Further directed cases put busy against an unrecognised tag and show which one wins. They also run conditional starts under several flag patterns to show that the correct flag bit is selected. A long seeded random mix of starts, address writes, reads, wipes and completions, with and without faults, is checked against a bench model. This mix exposes ordering errors that only appear when starts land in the awaiting-address, running or fault-parked states.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_AWAIT = 2'd1,
    ST_RUN   = 2'd2
  } seq_st_t;

  localparam int RSP_W = 16;

  localparam logic [1:0] REG_GEN   = 2'd0;
  localparam logic [1:0] REG_CND   = 2'd1;
  localparam logic [1:0] REG_RESP  = 2'd2;
  localparam logic [1:0] REG_IADDR = 2'd3;

  localparam logic [3:0] TAG_GEN = 4'hC;
  localparam logic [3:0] TAG_CND = 4'hD;

  localparam logic [RSP_W-1:0] RSP_NULL    = 16'h0000;
  localparam logic [RSP_W-1:0] RSP_BUSY    = 16'h2000;
  localparam logic [RSP_W-1:0] RSP_RELEASE = 16'h4800;
  localparam logic [RSP_W-1:0] RSP_COND    = 16'h6000;
  localparam logic [RSP_W-1:0] RSP_PREX    = 16'hE000;
endpackage

// File: rtl/cpx_start_decode.sv
module cpx_start_decode
  import cpx_pkg::*;
#(
  parameter int OP_W   = 12,
  parameter int COND_N = 8
) (
  input  logic [15:0]       word,
  input  logic              is_cond,
  input  logic [COND_N-1:0] flags,
  output logic              recog,
  output logic [OP_W-1:0]   op,
  output logic              pred
);
  localparam int PRED_W = (COND_N > 1) ? $clog2(COND_N) : 1;

  logic [3:0] want_tag;

  assign want_tag = is_cond ? TAG_CND : TAG_GEN;
  assign recog    = (word[15:12] == want_tag);
  assign op       = word[OP_W-1:0];

  generate
    if (COND_N == 1) begin : g_one
      assign pred = flags[0];
    end else begin : g_sel
      logic [PRED_W-1:0] idx;
      assign idx  = word[PRED_W-1:0];
      assign pred = (32'(idx) < COND_N) ? flags[idx] : 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cpx_fault_hold.sv
module cpx_fault_hold #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic [VEC_W-1:0]  set_vec,
  input  logic [DATA_W-1:0] set_addr,
  input  logic              ack_i,
  input  logic              wipe_i,
  output logic              pend_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [DATA_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      vec_o  <= '0;
      addr_o <= '0;
    end else begin
      if (set_i) begin
        pend_o <= 1'b1;
        vec_o  <= set_vec;
      end else if (ack_i) begin
        pend_o <= 1'b0;
      end
      if (set_i) begin
        addr_o <= set_addr;
      end else if (wipe_i) begin
        addr_o <= '0;
      end
    end
  end
endmodule

// File: rtl/cpx_seq.sv
module cpx_seq
  import cpx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 12,
  parameter int VEC_W  = 8,
  parameter logic [VEC_W-1:0] UNREC_VEC = 8'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic              start_cond,
  input  logic              wr_iaddr,
  input  logic              rd_resp,
  input  logic [DATA_W-1:0] wdata,
  input  logic              recog,
  input  logic [OP_W-1:0]   op,
  input  logic              pred,
  input  logic              pend,
  input  logic [VEC_W-1:0]  pend_vec,
  input  logic              exec_done,
  input  logic              exec_fault,
  output logic [RSP_W-1:0]  resp,
  output logic              ack_o,
  output logic              run_o,
  output logic              fault_set,
  output logic              exec_start,
  output logic [OP_W-1:0]   exec_op,
  output logic [DATA_W-1:0] exec_addr
);
  seq_st_t         st;
  logic            rdefer_q;
  logic [OP_W-1:0] op_q;

  assign run_o     = (st == ST_RUN);
  assign ack_o     = rd_resp && rdefer_q;
  assign fault_set = run_o && exec_done && exec_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      resp       <= RSP_NULL;
      rdefer_q   <= 1'b0;
      op_q       <= '0;
      exec_start <= 1'b0;
      exec_op    <= '0;
      exec_addr  <= '0;
    end else begin
      exec_start <= 1'b0;
      if (rd_resp) begin
        resp     <= RSP_NULL;
        rdefer_q <= 1'b0;
      end
      if (run_o && exec_done) begin
        st <= ST_IDLE;
      end
      if (wr_start) begin
        rdefer_q <= 1'b0;
        if (pend) begin
          resp     <= RSP_PREX | RSP_W'(pend_vec);
          rdefer_q <= 1'b1;
        end else if (st != ST_IDLE) begin
          resp <= RSP_BUSY;
        end else if (!recog) begin
          resp <= RSP_PREX | RSP_W'(UNREC_VEC);
        end else if (!start_cond) begin
          resp <= RSP_RELEASE;
          op_q <= op;
          st   <= ST_AWAIT;
        end else begin
          resp <= RSP_COND | RSP_W'(pred);
        end
      end
      if (wr_iaddr && st == ST_AWAIT) begin
        exec_start <= 1'b1;
        exec_op    <= op_q;
        exec_addr  <= wdata;
        st         <= ST_RUN;
      end
    end
  end
endmodule

// File: rtl/cpx_defer_resp.sv
module cpx_defer_resp
  import cpx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 12,
  parameter int VEC_W  = 8,
  parameter int COND_N = 8,
  parameter logic [VEC_W-1:0] UNREC_VEC = 8'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              exec_start,
  output logic [OP_W-1:0]   exec_op,
  output logic [DATA_W-1:0] exec_addr,
  input  logic              exec_done,
  input  logic              exec_fault,
  input  logic [VEC_W-1:0]  exec_vec,
  input  logic [COND_N-1:0] cond_flags
);
  logic              wr_start, start_cond, wr_iaddr, rd_resp, wipe;
  logic              recog, pred, pend_w, ack_w, run_w, fault_set;
  logic [OP_W-1:0]   dec_op;
  logic [VEC_W-1:0]  pend_vec;
  logic [DATA_W-1:0] faddr_w;
  logic [RSP_W-1:0]  resp_w;

  assign start_cond = (bus_addr == REG_CND);
  assign wr_start   = bus_wr && (bus_addr == REG_GEN || start_cond);
  assign wr_iaddr   = bus_wr && (bus_addr == REG_IADDR);
  assign wipe       = bus_wr && (bus_addr == REG_RESP);
  assign rd_resp    = bus_rd && (bus_addr == REG_RESP);

  cpx_start_decode #(.OP_W(OP_W), .COND_N(COND_N)) u_dec (
    .word    (bus_wdata[15:0]),
    .is_cond (start_cond),
    .flags   (cond_flags),
    .recog   (recog),
    .op      (dec_op),
    .pred    (pred)
  );

  cpx_fault_hold #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .set_i    (fault_set),
    .set_vec  (exec_vec),
    .set_addr (exec_addr),
    .ack_i    (ack_w),
    .wipe_i   (wipe),
    .pend_o   (pend_w),
    .vec_o    (pend_vec),
    .addr_o   (faddr_w)
  );

  cpx_seq #(.DATA_W(DATA_W), .OP_W(OP_W), .VEC_W(VEC_W), .UNREC_VEC(UNREC_VEC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .wr_start   (wr_start),
    .start_cond (start_cond),
    .wr_iaddr   (wr_iaddr),
    .rd_resp    (rd_resp),
    .wdata      (bus_wdata),
    .recog      (recog),
    .op         (dec_op),
    .pred       (pred),
    .pend       (pend_w),
    .pend_vec   (pend_vec),
    .exec_done  (exec_done),
    .exec_fault (exec_fault),
    .resp       (resp_w),
    .ack_o      (ack_w),
    .run_o      (run_w),
    .fault_set  (fault_set),
    .exec_start (exec_start),
    .exec_op    (exec_op),
    .exec_addr  (exec_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        REG_RESP:  bus_rdata <= DATA_W'(resp_w);
        REG_IADDR: bus_rdata <= faddr_w;
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cpx_defer_chk.sv
module cpx_defer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              exec_start,
  input logic              exec_done,
  input logic              exec_fault,
  input logic              run,
  input logic              pend,
  input logic [15:0]       resp
);
  p_start_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> !exec_start);

  p_start_from_addr_r4: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> $past(bus_wr && bus_addr == 2'd3));

  p_busy_answer_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !pend && bus_wr && bus_addr < 2'd2) |=> (resp == 16'h2000));

  p_fault_parked_r6: assert property (@(posedge clk) disable iff (rst)
    (run && exec_done && exec_fault) |=> pend);

  p_defer_report_r7: assert property (@(posedge clk) disable iff (rst)
    (pend && bus_wr && bus_addr < 2'd2) |=> (resp[15:13] == 3'b111 && !exec_start));

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (pend && !bus_wr && bus_rd && bus_addr == 2'd2 && resp[15:13] == 3'b111) |=> !pend);

  p_resp_consumed_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd && !bus_wr && bus_addr == 2'd2) && bus_rd && !bus_wr && bus_addr == 2'd2)
      |=> (bus_rdata == '0));
endmodule

bind cpx_defer_resp cpx_defer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .exec_start (exec_start),
  .exec_done  (exec_done),
  .exec_fault (exec_fault),
  .run        (run_w),
  .pend       (pend_w),
  .resp       (resp_w)
);

// File: tb/cpx_defer_resp_bench.sv
`timescale 1ns/1ps
module cpx_defer_resp_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        exec_start;
  logic [11:0] exec_op;
  logic [31:0] exec_addr;
  logic        exec_done = 1'b0, exec_fault = 1'b0;
  logic [7:0]  exec_vec = '0;
  logic [7:0]  cond_flags = '0;

  int n_chk = 0, n_fail = 0, start_cnt = 0;

  int          m_st = 0;
  bit          m_pend = 0, m_rdef = 0;
  logic [7:0]  m_vec = '0;
  logic [11:0] m_op = '0;
  logic [15:0] m_resp = '0;
  logic [31:0] m_faddr = '0, m_iaddr = '0;

  always #10 clk = ~clk;

  cpx_defer_resp u_cpx_defer_resp (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .exec_start(exec_start),
    .exec_op(exec_op), .exec_addr(exec_addr), .exec_done(exec_done),
    .exec_fault(exec_fault), .exec_vec(exec_vec), .cond_flags(cond_flags)
  );

  always @(posedge clk) begin
    #1;
    if (exec_start) start_cnt++;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [15:0] exp_start(input bit is_cond, input logic [15:0] w);
    if (m_pend) return 16'hE000 | 16'(m_vec);
    if (m_st != 0) return 16'h2000;
    if (w[15:12] != (is_cond ? 4'hD : 4'hC)) return 16'hE00B;
    if (!is_cond) return 16'h4800;
    return 16'h6000 | 16'(cond_flags[w[2:0]]);
  endfunction

  task automatic op_start(input bit is_cond, input logic [15:0] w, input string tag);
    int n0 = start_cnt;
    m_resp = exp_start(is_cond, w);
    m_rdef = m_pend;
    if (!m_pend && m_st == 0 && !is_cond && w[15:12] == 4'hC) begin
      m_st = 1; m_op = w[11:0];
    end
    do_wr(is_cond ? 2'd1 : 2'd0, {16'h0, w});
    chk({tag, " no launch on start"}, start_cnt - n0, 0);
  endtask

  task automatic op_addr(input logic [31:0] a, input string tag);
    int n0 = start_cnt;
    do_wr(2'd3, a);
    if (m_st == 1) begin
      chk({tag, " launch pulse"}, start_cnt - n0, 1);
      chk({tag, " exec_op"}, 32'(exec_op), 32'(m_op));
      chk({tag, " exec_addr"}, exec_addr, a);
      m_st = 2; m_iaddr = a;
    end else begin
      chk({tag, " stray address"}, start_cnt - n0, 0);
    end
  endtask

  task automatic op_rresp(input string tag);
    logic [31:0] d;
    do_rd(2'd2, d);
    chk(tag, d, {16'h0, m_resp});
    if (m_rdef) m_pend = 0;
    m_rdef = 0; m_resp = '0;
  endtask

  task automatic op_rfa(input string tag);
    logic [31:0] d;
    do_rd(2'd3, d);
    chk(tag, d, m_faddr);
  endtask

  task automatic op_wipe();
    do_wr(2'd2, $urandom);
    m_faddr = '0;
  endtask

  task automatic op_done(input bit f, input logic [7:0] v);
    @(negedge clk); exec_done = 1'b1; exec_fault = f; exec_vec = v;
    @(negedge clk); exec_done = 1'b0; exec_fault = 1'b0;
    if (m_st == 2) begin
      m_st = 0;
      if (f) begin m_pend = 1; m_vec = v; m_faddr = m_iaddr; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata after reset", bus_rdata, 0);
    chk("R1 exec_start after reset", 32'(exec_start), 0);
    op_rresp("R1 first response null");

    op_start(0, 16'hC012, "R3 general");
    op_rresp("R3 release code");
    op_start(0, 16'hC0FF, "R5 while awaiting");
    op_rresp("R5 busy awaiting");
    op_addr(32'h0000_1230, "R4 address");
    op_addr(32'h0000_9999, "R4 address while running");
    op_start(0, 16'hC001, "R5 while running");
    op_rresp("R5 busy running");

    op_done(1, 8'h31);
    op_rresp("R6 fault not reported");
    op_rfa("R6 fault address");
    op_start(0, 16'hC044, "R7 start with fault parked");
    op_rresp("R7 deferred vector");
    op_addr(32'h0000_7777, "R7 not begun");
    op_start(0, 16'hC044, "R8 restart");
    op_rresp("R8 normal release after ack");
    op_addr(32'h0000_2000, "R8 restart launch");
    op_rfa("R9 address kept over starts");
    op_done(0, 8'h00);
    op_rfa("R9 address kept after clean end");
    op_wipe();
    op_rfa("R9 address wiped");
    op_rresp("R10 null when nothing started");

    op_start(0, 16'h5012, "R2 bad general tag");
    op_rresp("R2 unrecognised general");
    op_start(1, 16'hC003, "R2 bad conditional tag");
    op_rresp("R2 unrecognised conditional");
    op_rresp("R10 consumed");

    cond_flags = 8'b0010_0100;
    op_start(1, 16'hD002, "R11 flag set");
    op_rresp("R11 true");
    op_start(1, 16'hD003, "R11 flag clear");
    op_rresp("R11 false");
    cond_flags = 8'b1000_0000;
    op_start(1, 16'hD007, "R11 top flag");
    op_rresp("R11 top true");

    op_start(0, 16'hC100, "R5 prep");
    op_rresp("R3 release again");
    op_addr(32'hABCD_0004, "R4 launch");
    op_start(0, 16'h7000, "R5 busy beats bad tag");
    op_rresp("R5 busy over unrecognised");
    op_done(1, 8'h22);
    op_start(1, 16'hD001, "R7 conditional with fault parked");
    op_rresp("R7 deferred on conditional");
    op_rfa("R6 second fault address");

    for (int i = 0; i < 500; i++) begin
      int r = $urandom_range(0, 9);
      case (r)
        0, 1, 2: begin
          bit c = (r == 2);
          logic [3:0] t = c ? 4'hD : 4'hC;
          if ($urandom_range(0, 3) == 0) begin
            t = 4'($urandom_range(0, 15));
            if (t == (c ? 4'hD : 4'hC)) t = 4'h3;
          end
          cond_flags = 8'($urandom);
          op_start(c, {t, 12'($urandom)}, "R2/R3/R5/R7/R11 random start");
        end
        3, 4: op_addr($urandom, "R4/R7 random address");
        5, 6: op_rresp("R2/R3/R5/R7/R8/R10/R11 random response");
        7: op_rfa("R6/R9 random fault address");
        8: if ($urandom_range(0, 2) == 0) op_wipe(); else op_done(0, 8'h00);
        default: op_done($urandom_range(0, 1) == 1, 8'($urandom));
      endcase
    end
    repeat (2) @(negedge clk);
    report();
  end
endmodule